// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the digital receive side of a serial-input digital-to-analog converter. A fast system clock samples the slow serial pins: the serial clock, the active-low frame strobe, the data line, the active-low latch-load strobe, the active-low clear and the chain-mode select. After synchronization it finds their edges. Data is shifted MSB first into a 16-bit input register on serial-clock falling edges while the frame strobe is low. A DAC latch then takes the word, either at once or later under control of the load strobe. The analog conversion is not modelled. A one-cycle strobe marks the point where the converter output may be treated as settled.

There are two modes. In standalone mode, a bit counter lets exactly 16 bits in per frame, so burst and free-running serial clocks both work. In chain mode, every serial-clock fall inside a frame shifts the register. The bit that falls out of the MSB end goes to a serial output, which feeds the next device in the chain. A parameter sets the latch width to 16 or 14 bits. In the 14-bit case the latch keeps the top 14 bits of the 16-bit word.

Top module: `sdac_rx_front`

## Requirements
- R1: After reset the latch output is zero, and the serial output, the valid strobe and the protocol error strobe are low.
- R2: A bit is taken from the data pin on a falling edge of the serial clock only while the frame strobe is low, and bits enter the word MSB first. Serial-clock falls while the frame strobe is high change nothing.
- R3: With chain select low (standalone), only the first 16 falling edges after the frame strobe falls are accepted. Further edges in the same frame leave both the word and the latch unchanged.
- R4: If the load strobe is low when the frame strobe falls (auto mode), the latch takes the completed word on the 16th accepted edge, with no load-strobe activity.
- R5: If the load strobe is high when the frame strobe falls (deferred mode), the latch keeps its value through the frame. It takes the word on the first load-strobe fall after the frame strobe has risen with all 16 bits received.
- R6: The valid strobe is a one-cycle pulse. In auto mode it rises together with the new latch value. In deferred mode it rises SETTLE_CYC clock cycles after the latch update.
- R7: If the frame strobe falls while the load strobe is still low, and the previous frame was deferred or chained, the protocol error output pulses for one cycle.
- R8: With chain select high (1 = chain), every accepted edge shifts the word, with no 16-bit limit. The serial output changes on that edge to the bit shifted out of the MSB, and the latch loads only on a load-strobe fall. With chain select low, the serial output is held low.
- R9: While the clear input is low, the latch is forced to zero, all loads are ignored and any pending valid pulse is cancelled.
- R10: With DAC_W = 14, the latch holds bits 15 down to 2 of the received word. The last two bits of the 16 are dropped.
- R11: If the frame strobe rises in standalone mode before 16 bits have arrived, the frame is aborted. The latch is not updated, either then or by a later load-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sync_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low latch-load strobe; mode sampled at frame start |
| clr_n_i | input | 1 | Active-low latch clear |
| chain_en_i | input | 1 | 1 selects chain mode, 0 standalone |
| latch_o | output | DAC_W | DAC latch contents |
| sdout_o | output | 1 | Serial output to the next chained device |
| out_valid_o | output | 1 | One-cycle strobe: converter output settled |
| proto_err_o | output | 1 | One-cycle strobe: frame began with load strobe low after a deferred frame |

## Verification
Every pin passes through two synchronizer flops and one edge-detect flop. A pin change set up before clock edge k therefore acts on edge k+2, and the latch, serial output, error and auto-mode valid results can be seen after that edge. A deferred valid pulse follows SETTLE_CYC edges after its latch update. The reference model delays its copy of the pins by the same two stages and applies the rules at each rising edge. Outputs are compared on the falling edge, half a period after the edge that updated them. The bench also waits at least three clocks after each pin change before making its directed checks.

// File: rtl/sdac_pkg.sv
// Shared definitions for the serial DAC input front end.
// Pin vector order is fixed: the first EDGE_N pins get edge detection.
package sdac_pkg;
    localparam int PIN_N  = 6;
    localparam int EDGE_N = 3;
    localparam int P_SCLK  = 0;
    localparam int P_SYNC  = 1;
    localparam int P_LDAC  = 2;
    localparam int P_SDIN  = 3;
    localparam int P_CLR   = 4;
    localparam int P_CHAIN = 5;
    // idle levels: sclk high, strobes high, data low, clear high, chain off
    localparam logic [PIN_N-1:0] PIN_IDLE = 6'b010111;

    // decoded pin events for one system-clock cycle
    typedef struct packed {
        logic sclk_fall;
        logic sync_fall;
        logic sync_rise;
        logic ldac_fall;
        logic sync_low;
        logic ldac_high;
        logic clr_act;
        logic sdin;
        logic chain;
    } pin_ev_t;
endpackage

// File: rtl/sdac_pin_sync.sv
// Two-flop synchronizer for each pin, plus a previous-value flop for the
// first EDGE_N pins, so the parent can decode edges.
// Assumes pins are quasi-static relative to clk (slow serial interface).
module sdac_pin_sync #(
    parameter int N = 6,
    parameter int EDGE_N = 3,
    parameter logic [N-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] lvl_o,
    output logic [EDGE_N-1:0] prv_o
);
    logic [N-1:0] meta_q;

    for (genvar g = 0; g < N; g++) begin : g_pin
        // synchronize one pin through two flops
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= IDLE[g];
                lvl_o[g]  <= IDLE[g];
            end else begin
                meta_q[g] <= pins_i[g];
                lvl_o[g]  <= meta_q[g];
            end
        end
        if (g < EDGE_N) begin : g_edge
            // hold the previous synchronized level for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) prv_o[g] <= IDLE[g];
                else        prv_o[g] <= lvl_o[g];
            end
        end
    end
endmodule

// File: rtl/sdac_shift_front.sv
// Input shift register, gating bit counter, frame mode capture, chain
// serial output and load request generation.
// Assumes a serial-clock fall and a frame-strobe fall never share a cycle;
// if they do, the frame start wins and the bit is dropped.
module sdac_shift_front
    import sdac_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ev_t           ev,
    output logic [WORD_W-1:0] ld_data_o,
    output logic              ld_req_o,
    output logic              ld_auto_o,
    output logic              sdout_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic              frame_def_q;
    logic              ready_q;
    logic              shift_en;
    logic              auto_ld;
    logic              def_ld;

    // decide whether this cycle accepts a bit and whether a load fires
    always_comb begin
        shift_en = ev.sclk_fall && ev.sync_low && !ev.sync_fall
                   && (ev.chain || (cnt_q != FULL));
        word_nxt = {word_q[WORD_W-2:0], ev.sdin};
        auto_ld  = shift_en && !frame_def_q && !ev.chain && (cnt_q == LAST);
        def_ld   = ev.ldac_fall && ready_q && !ev.clr_act;
    end

    // count accepted bits, saturating at a full word
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (ev.sync_fall)              cnt_q <= '0;
        else if (shift_en && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end

    // shift the data bit in at the LSB end
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= word_nxt;
    end

    // present the bit leaving the MSB end in chain mode
    always_ff @(posedge clk) begin
        if (!rst_n)         sdout_o <= 1'b0;
        else if (!ev.chain) sdout_o <= 1'b0;
        else if (shift_en)  sdout_o <= word_q[WORD_W-1];
    end

    // capture the update mode when a frame opens
    always_ff @(posedge clk) begin
        if (!rst_n)            frame_def_q <= 1'b0;
        else if (ev.sync_fall) frame_def_q <= ev.ldac_high || ev.chain;
    end

    // flag a frame opened while the load strobe still hangs low
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= ev.sync_fall && !ev.ldac_high && frame_def_q;
    end

    // mark a complete word waiting for a load-strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)            ready_q <= 1'b0;
        else if (ev.sync_fall) ready_q <= 1'b0;
        else if (def_ld)       ready_q <= 1'b0;
        else if (ev.sync_rise && cnt_q == FULL && frame_def_q)
                               ready_q <= 1'b1;
    end

    assign ld_req_o  = auto_ld || def_ld;
    assign ld_auto_o = auto_ld;
    assign ld_data_o = auto_ld ? word_nxt : word_q;
    assign cnt_o     = cnt_q;
endmodule

// File: rtl/sdac_latch_stage.sv
// DAC latch with clear, plus the settle timer that produces the output
// valid strobe. Keeps the top DAC_W bits of the word.
// Assumes SETTLE_CYC >= 1.
module sdac_latch_stage #(
    parameter int WORD_W = 16,
    parameter int DAC_W = 16,
    parameter int SETTLE_CYC = 625,
    localparam int T_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req_i,
    input  logic              ld_auto_i,
    input  logic [WORD_W-1:0] ld_data_i,
    input  logic              clr_i,
    output logic [DAC_W-1:0]  latch_o,
    output logic              valid_o
);
    localparam logic [T_W-1:0] T_LOAD = T_W'(SETTLE_CYC);
    localparam logic [T_W-1:0] T_ONE  = T_W'(1);

    logic [T_W-1:0] tmr_q;

    // hold, clear or load the latch
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_o <= '0;
        else if (clr_i)    latch_o <= '0;
        else if (ld_req_i) latch_o <= ld_data_i[WORD_W-1 -: DAC_W];
    end

    // time the settling delay after a deferred load
    always_ff @(posedge clk) begin
        if (!rst_n)                    tmr_q <= '0;
        else if (clr_i)                tmr_q <= '0;
        else if (ld_req_i && !ld_auto_i) tmr_q <= T_LOAD;
        else if (tmr_q != '0)          tmr_q <= tmr_q - 1'b1;
    end

    // pulse valid at once for auto loads, at timer expiry for deferred
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_o <= 1'b0;
        else if (clr_i) valid_o <= 1'b0;
        else            valid_o <= (ld_req_i && ld_auto_i) || (tmr_q == T_ONE);
    end
endmodule

// File: rtl/sdac_rx_front.sv
// Top of the serial DAC input front end: synchronizes the pins, decodes
// edges and joins the shift front to the latch stage.
// Assumes the serial clock half-period spans at least two system clocks.
module sdac_rx_front
    import sdac_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DAC_W = 16,
    parameter int SETTLE_CYC = 625,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sync_n_i,
    input  logic             sdin_i,
    input  logic             ldac_n_i,
    input  logic             clr_n_i,
    input  logic             chain_en_i,
    output logic [DAC_W-1:0] latch_o,
    output logic             sdout_o,
    output logic             out_valid_o,
    output logic             proto_err_o
);
    logic [PIN_N-1:0]  pins;
    logic [PIN_N-1:0]  lvl;
    logic [EDGE_N-1:0] prv;
    pin_ev_t           ev;
    logic [WORD_W-1:0] ld_data;
    logic              ld_req;
    logic              ld_auto;
    logic              clr_act;
    logic              sync_fall;
    logic              chain_act;
    logic [CNT_W-1:0]  bit_cnt;

    assign pins = {chain_en_i, clr_n_i, sdin_i, ldac_n_i, sync_n_i, sclk_i};

    sdac_pin_sync #(.N(PIN_N), .EDGE_N(EDGE_N), .IDLE(PIN_IDLE)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .lvl_o  (lvl),
        .prv_o  (prv)
    );

    // decode levels and edges from the synchronized pins
    always_comb begin
        ev.sclk_fall = prv[P_SCLK] && !lvl[P_SCLK];
        ev.sync_fall = prv[P_SYNC] && !lvl[P_SYNC];
        ev.sync_rise = !prv[P_SYNC] && lvl[P_SYNC];
        ev.ldac_fall = prv[P_LDAC] && !lvl[P_LDAC];
        ev.sync_low  = !lvl[P_SYNC];
        ev.ldac_high = lvl[P_LDAC];
        ev.clr_act   = !lvl[P_CLR];
        ev.sdin      = lvl[P_SDIN];
        ev.chain     = lvl[P_CHAIN];
    end

    assign clr_act   = ev.clr_act;
    assign sync_fall = ev.sync_fall;
    assign chain_act = ev.chain;

    sdac_shift_front #(.WORD_W(WORD_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .ld_data_o (ld_data),
        .ld_req_o  (ld_req),
        .ld_auto_o (ld_auto),
        .sdout_o   (sdout_o),
        .err_o     (proto_err_o),
        .cnt_o     (bit_cnt)
    );

    sdac_latch_stage #(.WORD_W(WORD_W), .DAC_W(DAC_W), .SETTLE_CYC(SETTLE_CYC)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_req_i  (ld_req),
        .ld_auto_i (ld_auto),
        .ld_data_i (ld_data),
        .clr_i     (clr_act),
        .latch_o   (latch_o),
        .valid_o   (out_valid_o)
    );
endmodule

// File: rtl/sdac_rx_front_chk.sv
// Property checker for the serial DAC input front end, bound to the top.
module sdac_rx_front_chk #(
    parameter int WORD_W = 16,
    parameter int DAC_W = 16,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DAC_W-1:0] latch_o,
    input logic             sdout_o,
    input logic             out_valid_o,
    input logic             proto_err_o,
    input logic             ld_req,
    input logic             ld_auto,
    input logic             clr_act,
    input logic             sync_fall,
    input logic             chain_act,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL); // R3
    AST_LATCH_CHANGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_o) |-> $past(ld_req || clr_act)); // R4
    AST_AUTO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_auto && !clr_act) |=> out_valid_o); // R6
    AST_ERR_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(sync_fall)); // R7
    AST_SDOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_act |=> !sdout_o); // R8
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (latch_o == '0)); // R9
    AST_CLR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> !out_valid_o); // R9
endmodule

bind sdac_rx_front sdac_rx_front_chk #(.WORD_W(WORD_W), .DAC_W(DAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_o     (latch_o),
    .sdout_o     (sdout_o),
    .out_valid_o (out_valid_o),
    .proto_err_o (proto_err_o),
    .ld_req      (ld_req),
    .ld_auto     (ld_auto),
    .clr_act     (clr_act),
    .sync_fall   (sync_fall),
    .chain_act   (chain_act),
    .bit_cnt     (bit_cnt)
);

// File: tb/sdac_rx_front_tb_top.sv
// Self-checking bench: behavioural reference model with a pin-history
// queue and a bit queue, compared on every falling clock edge, plus
// directed checks per requirement.
module sdac_rx_front_tb_top;
    localparam int SETTLE = 50;
    localparam logic [5:0] IDLE = 6'b010111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
    logic ldac_n = 1'b1, clr_n = 1'b1, chain_en = 1'b0;
    logic [15:0] latch16;
    logic [13:0] latch14;
    logic sdout16, sdout14, valid16, valid14, err16, err14;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int vcnt = 0;
    int ecnt = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    sdac_rx_front #(.WORD_W(16), .DAC_W(16), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n),
        .sdin_i(sdin), .ldac_n_i(ldac_n), .clr_n_i(clr_n), .chain_en_i(chain_en),
        .latch_o(latch16), .sdout_o(sdout16), .out_valid_o(valid16),
        .proto_err_o(err16));

    sdac_rx_front #(.WORD_W(16), .DAC_W(14), .SETTLE_CYC(SETTLE)) dut14_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n),
        .sdin_i(sdin), .ldac_n_i(ldac_n), .clr_n_i(clr_n), .chain_en_i(chain_en),
        .latch_o(latch14), .sdout_o(sdout14), .out_valid_o(valid14),
        .proto_err_o(err14));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [5:0] h1 = IDLE, h2 = IDLE, h3 = IDLE;
    bit   q[$];
    logic [15:0] m_latch = '0;
    logic m_sdout = 0, m_valid = 0, m_err = 0, m_def = 0, m_rdy = 0;
    int   m_cnt = 0, m_tmr = 0;

    function automatic logic [15:0] qword();
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[15-i] = q[i];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = IDLE; h2 = IDLE; h3 = IDLE;
            q.delete();
            for (int i = 0; i < 16; i++) q.push_back(1'b0);
            m_latch = '0; m_sdout = 0; m_valid = 0; m_err = 0;
            m_def = 0; m_rdy = 0; m_cnt = 0; m_tmr = 0;
        end else begin
            // pins as the design sees them two stages late: {chain,clr,sdin,ldac,sync,sclk}
            bit sclk_f, sync_f, sync_r, ldac_f, clr, chain, din, ldac_hi, sync_lo;
            bit old_rdy;
            sclk_f  = h3[0] & ~h2[0];
            sync_f  = h3[1] & ~h2[1];
            sync_r  = ~h3[1] & h2[1];
            ldac_f  = h3[2] & ~h2[2];
            ldac_hi = h2[2];
            sync_lo = ~h2[1];
            din     = h2[3];
            clr     = ~h2[4];
            chain   = h2[5];
            old_rdy = m_rdy;
            m_valid = 0;
            m_err   = 0;
            if (m_tmr > 0) begin
                m_tmr--;
                if (m_tmr == 0) m_valid = 1;
            end
            if (ldac_f && old_rdy && !clr) begin
                m_latch = qword();
                m_tmr = SETTLE;
                m_rdy = 0;
            end
            if (sync_f) begin
                m_err = !ldac_hi && m_def;
                m_def = ldac_hi || chain;
                m_cnt = 0;
                m_rdy = 0;
            end else if (sclk_f && sync_lo && (chain || m_cnt < 16)) begin
                bit out_bit;
                q.push_back(din);
                out_bit = q.pop_front();
                if (chain) m_sdout = out_bit;
                if (m_cnt < 16) m_cnt++;
                if (m_cnt == 16 && !m_def && !chain && !clr) begin
                    m_latch = qword();
                    m_valid = 1;
                end
            end
            if (sync_r && m_cnt == 16 && m_def && !(ldac_f && old_rdy && !clr)) m_rdy = 1;
            if (!chain) m_sdout = 0;
            if (clr) begin
                m_latch = '0; m_tmr = 0; m_valid = 0;
            end
            h3 = h2; h2 = h1;
            h1 = {chain_en, clr_n, sdin, ldac_n, sync_n, sclk};
            cyc++;
        end
    end

    // per-cycle comparison, half a period after the updating edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(latch16 == m_latch, "R4 latch", latch16, m_latch);
            chk(latch14 == m_latch[15:2], "R10 latch14", latch14, m_latch[15:2]);
            chk(sdout16 == m_sdout, "R8 sdout", sdout16, m_sdout);
            chk(valid16 == m_valid, "R6 valid", valid16, m_valid);
            chk(err16 == m_err, "R7 err", err16, m_err);
            if (valid16) vcnt++;
            if (err16) ecnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(input logic d, output logic so);
        sdin = d; sclk = 1'b0;
        idle(3);
        so = sdout16;
        sclk = 1'b1;
        idle(3);
    endtask

    task automatic frame(input logic [31:0] data, input int nbits,
                         input logic ldac_lvl, output logic [31:0] cap);
        logic so;
        cap = '0;
        ldac_n = ldac_lvl;
        idle(4);
        sync_n = 1'b0;
        idle(4);
        for (int i = 0; i < nbits; i++) begin
            sclk_pulse(data[nbits-1-i], so);
            cap = {cap[30:0], so};
        end
        idle(3);
        sync_n = 1'b1;
        idle(6);
    endtask

    task automatic ldac_pulse();
        ldac_n = 1'b0; idle(4);
        ldac_n = 1'b1; idle(4);
    endtask

    task automatic run_tests();
        logic [31:0] cap;
        logic so;
        int v0, e0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        chk(latch16 == 16'h0, "R1 latch", latch16, 0);
        chk(!sdout16 && !valid16 && !err16, "R1 strobes", {sdout16, valid16, err16}, 0);

        // R2 R4 R6: auto frame, MSB first, valid pulse with load
        v0 = vcnt;
        frame(32'h0000A5C3, 16, 1'b0, cap);
        chk(latch16 == 16'hA5C3, "R2 msb first", latch16, 16'hA5C3);
        chk(latch16 == 16'hA5C3, "R4 auto load", latch16, 16'hA5C3);
        chk(vcnt == v0 + 1, "R6 auto valid", vcnt - v0, 1);

        // R3: 20 edges in standalone, only first 16 kept
        frame(32'h0001234F, 20, 1'b0, cap);
        chk(latch16 == 16'h1234, "R3 gate 16", latch16, 16'h1234);
        chk(sdout16 == 1'b0, "R8 standalone sdout", sdout16, 0);

        // R5 R6: deferred frame, load on strobe fall, valid after settle
        frame(32'h00000F0F, 16, 1'b1, cap);
        chk(latch16 == 16'h1234, "R5 hold in frame", latch16, 16'h1234);
        v0 = vcnt;
        ldac_pulse();
        chk(latch16 == 16'h0F0F, "R5 load on fall", latch16, 16'h0F0F);
        chk(vcnt == v0, "R6 no early valid", vcnt - v0, 0);
        idle(SETTLE + 5);
        chk(vcnt == v0 + 1, "R6 settle valid", vcnt - v0, 1);

        // R11: aborted frames leave latch alone
        frame(32'h000000AA, 8, 1'b1, cap);
        ldac_pulse();
        chk(latch16 == 16'h0F0F, "R11 deferred abort", latch16, 16'h0F0F);
        frame(32'h00000333, 10, 1'b0, cap);
        chk(latch16 == 16'h0F0F, "R11 auto abort", latch16, 16'h0F0F);
        ldac_n = 1'b1; idle(4);

        // R7: frame opened with strobe low after deferred frame
        frame(32'h00005555, 16, 1'b1, cap);
        ldac_n = 1'b0; idle(6);
        chk(latch16 == 16'h5555, "R5 deferred 5555", latch16, 16'h5555);
        e0 = ecnt;
        frame(32'h00003C3C, 16, 1'b0, cap);
        chk(ecnt == e0 + 1, "R7 error pulse", ecnt - e0, 1);
        chk(latch16 == 16'h3C3C, "R4 auto after err", latch16, 16'h3C3C);
        chk(latch14 == 14'h0F0F, "R10 top bits", latch14, 14'h0F0F);
        frame(32'h0000FFFC, 16, 1'b0, cap);
        chk(ecnt == e0 + 1, "R7 no error after auto", ecnt - e0, 1);
        chk(latch14 == 14'h3FFF, "R10 trailing zeros", latch14, 14'h3FFF);
        ldac_n = 1'b1; idle(4);

        // R9: clear, loads ignored, pending valid cancelled
        frame(32'h00001111, 16, 1'b1, cap);
        v0 = vcnt;
        ldac_pulse();
        chk(latch16 == 16'h1111, "R5 deferred 1111", latch16, 16'h1111);
        clr_n = 1'b0; idle(6);
        chk(latch16 == 16'h0, "R9 clear", latch16, 0);
        frame(32'h00007777, 16, 1'b0, cap);
        chk(latch16 == 16'h0, "R9 load ignored", latch16, 0);
        clr_n = 1'b1; ldac_n = 1'b1;
        idle(SETTLE + 10);
        chk(vcnt == v0, "R9 valid cancelled", vcnt - v0, 0);
        chk(latch16 == 16'h0, "R9 stays zero", latch16, 0);

        // R8 R2: chain mode, 32 bits, first word rippled out
        chain_en = 1'b1; idle(4);
        frame(32'hBEEFCAFE, 32, 1'b1, cap);
        chk(cap[15:0] == 16'hBEEF, "R8 ripple out", cap[15:0], 16'hBEEF);
        chk(latch16 == 16'h0, "R8 no auto load", latch16, 0);
        for (int i = 0; i < 4; i++) sclk_pulse(1'b1, so);
        ldac_pulse();
        chk(latch16 == 16'hCAFE, "R2 sync high ignored", latch16, 16'hCAFE);
        chain_en = 1'b0; idle(6);
        chk(sdout16 == 1'b0, "R8 sdout low", sdout16, 0);
        idle(SETTLE + 5);
    endtask

    initial begin
        fork
            run_tests();
            begin
                wait (cyc >= 150000);
                fails++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
            end
        join_any
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule